// File: doc/BRIEF.md
# Off-Hook Settling and Calibration Sequencer

This block takes a telephone line interface from on-hook to the point where transmit and receive may start. When software sets the off-hook request, the sequencer first waits out the fixed delay the command needs to reach the line side. It then raises the line-seize output and runs a settling interval of selectable length. Two calibration intervals follow: first the resistor calibration, then the converter offset calibration. Each one can be skipped on its own. After the last enabled interval the block raises a ready flag that gates the data path.

All intervals are counted in ticks of a prescaled time base. One tick is 250 µs. `TICK_DIV` sets how many clock cycles make one tick, so a bench can use a short tick. The settling-time select and both skip bits are captured in the cycle the sequence leaves idle. Clearing the request in any phase aborts the sequence at once.

Top module: `offhook_sequencer`

## Requirements
- R1: After reset, `phase` is 0 (idle) and `line_seize`, `rcal_busy`, `acal_busy` and `link_ready` are all low.
- R2: After `offhook_req` is sampled high in idle, the block spends 1 tick (250 µs) in phase 1 (latency) with `line_seize` low. `line_seize` is high in every phase from settling onward.
- R3: Settling (phase 2) lasts according to `settle_sel`: 00 = 512 ticks (128 ms), 01 = 256 ticks (64 ms), 10 = 2048 ticks (512 ms), 11 = 32 ticks (8 ms).
- R4: Resistor calibration (phase 3, `rcal_busy` high) lasts 68 ticks (17 ms). It is skipped entirely when `rcal_off` is 1.
- R5: Converter calibration (phase 4, `acal_busy` high) lasts 1024 ticks (256 ms). It is skipped entirely when `acal_off` is 1.
- R6: Phases always run in the order latency, settling, resistor calibration, converter calibration, ready. Skipped phases are passed over and never entered.
- R7: `offhook_req` low in any phase returns the block to idle on the next clock edge, with every output low.
- R8: `link_ready` (phase 5) rises only after the last enabled phase has ended. It stays high for as long as `offhook_req` stays high.
- R9: `settle_sel`, `rcal_off` and `acal_off` are captured on the edge that leaves idle. Changing them later in the same sequence has no effect on it.
- R10: `phase` encodes 0 idle, 1 latency, 2 settling, 3 resistor calibration, 4 converter calibration, 5 ready.
- R11: An interval of N ticks occupies exactly N × `TICK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offhook_req | input | 1 | Software request to seize the line |
| settle_sel | input | 2 | Settling-time select |
| rcal_off | input | 1 | Skip resistor calibration |
| acal_off | input | 1 | Skip converter calibration |
| line_seize | output | 1 | Line side is off-hook |
| rcal_busy | output | 1 | Resistor calibration in progress |
| acal_busy | output | 1 | Converter calibration in progress |
| link_ready | output | 1 | Transmit and receive allowed |
| phase | output | 3 | Current phase code |

## Verification
The assertions check several rules on every cycle:
- a dropped request forces idle on the next edge;
- ready holds while the request stays high;
- line seizure begins only when the latency phase ends;
- converter calibration is entered only from settling or resistor calibration;
- a skipped resistor calibration is never entered;
- the tick and interval counters stay inside their bounds.

Only the bench scenarios can show the exact length of each interval for every settling code and skip combination. They also show that inputs changed mid-sequence are ignored, and that an abort at an arbitrary cycle lands in idle.

// File: rtl/ohs_pkg.sv
package ohs_pkg;
  localparam int TICK_W = 12;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LAT    = 3'd1,
    PH_SETTLE = 3'd2,
    PH_RCAL   = 3'd3,
    PH_ACAL   = 3'd4,
    PH_READY  = 3'd5
  } phase_e;

  // settling length in 250 us ticks; code 00 is the default 128 ms
  function automatic logic [TICK_W-1:0] settle_ticks(input logic [1:0] sel);
    case (sel)
      2'b00:   settle_ticks = TICK_W'(512);
      2'b01:   settle_ticks = TICK_W'(256);
      2'b10:   settle_ticks = TICK_W'(2048);
      default: settle_ticks = TICK_W'(32);
    endcase
  endfunction

  // phase that follows the one just finished, honouring the skip bits
  function automatic phase_e after_phase(input phase_e cur, input logic skip_r,
                                         input logic skip_a);
    case (cur)
      PH_LAT:    after_phase = PH_SETTLE;
      PH_SETTLE: after_phase = skip_r ? (skip_a ? PH_READY : PH_ACAL) : PH_RCAL;
      PH_RCAL:   after_phase = skip_a ? PH_READY : PH_ACAL;
      PH_ACAL:   after_phase = PH_READY;
      default:   after_phase = cur;
    endcase
  endfunction
endpackage

// File: rtl/ohs_tick_gen.sv
module ohs_tick_gen #(
  parameter int DIV = 31250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R11
endmodule

// File: rtl/ohs_phase_timer.sv
module ohs_phase_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] target,
  output logic          done
);
  logic [TW-1:0] cnt;

  assign done = tick && (cnt == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> cnt < target); // R11
endmodule

// File: rtl/offhook_sequencer.sv
module offhook_sequencer
  import ohs_pkg::*;
#(
  parameter int TICK_DIV   = 31250,
  parameter int LAT_TICKS  = 1,
  parameter int RCAL_TICKS = 68,
  parameter int ACAL_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       offhook_req,
  input  logic [1:0] settle_sel,
  input  logic       rcal_off,
  input  logic       acal_off,
  output logic       line_seize,
  output logic       rcal_busy,
  output logic       acal_busy,
  output logic       link_ready,
  output logic [2:0] phase
);
  phase_e state, nxt;
  logic [1:0] cfg_sel;
  logic       cfg_rskip, cfg_askip;
  logic       tick, phase_done, restart;
  logic [TICK_W-1:0] target;

  // configuration is latched while idle, frozen once a sequence runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel   <= 2'b00;
      cfg_rskip <= 1'b0;
      cfg_askip <= 1'b0;
    end else if (state == PH_IDLE) begin
      cfg_sel   <= settle_sel;
      cfg_rskip <= rcal_off;
      cfg_askip <= acal_off;
    end
  end

  always_comb begin
    case (state)
      PH_LAT:    target = TICK_W'(LAT_TICKS);
      PH_SETTLE: target = settle_ticks(cfg_sel);
      PH_RCAL:   target = TICK_W'(RCAL_TICKS);
      PH_ACAL:   target = TICK_W'(ACAL_TICKS);
      default:   target = TICK_W'(1);
    endcase
  end

  always_comb begin
    nxt = state;
    if (!offhook_req)            nxt = PH_IDLE;
    else if (state == PH_IDLE)   nxt = PH_LAT;
    else if (phase_done && state != PH_READY)
      nxt = after_phase(state, cfg_rskip, cfg_askip);
  end

  assign restart = (nxt != state) || (state == PH_IDLE) || (state == PH_READY);

  ohs_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  ohs_phase_timer #(.TW(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .target(target), .done(phase_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= nxt;
  end

  assign phase      = state;
  assign line_seize = (state == PH_SETTLE) || (state == PH_RCAL) ||
                      (state == PH_ACAL)   || (state == PH_READY);
  assign rcal_busy  = (state == PH_RCAL);
  assign acal_busy  = (state == PH_ACAL);
  assign link_ready = (state == PH_READY);

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !offhook_req |=> (phase == 3'd0) && !line_seize); // R7
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && offhook_req) |=> link_ready); // R8
  AST_SEIZE_AFTER_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_seize) |-> $past(phase) == 3'd1); // R2
  AST_ACAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acal_busy) |-> ($past(phase) == 3'd2 || $past(phase) == 3'd3)); // R6
  AST_RCAL_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rskip && state != PH_IDLE) |-> !rcal_busy); // R4
endmodule

// File: tb/offhook_sequencer_bench.sv
`timescale 1ns/1ps
module offhook_sequencer_bench;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offhook_req = 1'b0;
  logic [1:0] settle_sel = 2'b00;
  logic rcal_off = 1'b0, acal_off = 1'b0;
  logic line_seize, rcal_busy, acal_busy, link_ready;
  logic [2:0] phase;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  offhook_sequencer #(.TICK_DIV(D)) u_offhook_sequencer (
    .clk(clk), .rst_n(rst_n), .offhook_req(offhook_req), .settle_sel(settle_sel),
    .rcal_off(rcal_off), .acal_off(acal_off), .line_seize(line_seize),
    .rcal_busy(rcal_busy), .acal_busy(acal_busy), .link_ready(link_ready),
    .phase(phase)
  );

  // settling in milliseconds, turned into 250 us ticks below
  function automatic int settle_ms(input logic [1:0] s);
    case (s)
      2'b00: return 128;
      2'b01: return 64;
      2'b10: return 512;
      default: return 8;
    endcase
  endfunction

  function automatic int ref_phase(input int k, input logic [1:0] s, input bit r, input bit a);
    int lat_end, set_end, rc_end, ac_end;
    lat_end = D;
    set_end = lat_end + settle_ms(s) * 4 * D;
    rc_end  = set_end + (r ? 0 : 17 * 4 * D);
    ac_end  = rc_end + (a ? 0 : 256 * 4 * D);
    if (k < lat_end) return 1;
    if (k < set_end) return 2;
    if (k < rc_end)  return 3;
    if (k < ac_end)  return 4;
    return 5;
  endfunction

  function automatic int total_len(input logic [1:0] s, input bit r, input bit a);
    return D + settle_ms(s) * 4 * D + (r ? 0 : 68 * D) + (a ? 0 : 1024 * D);
  endfunction

  task automatic check_out(input string req, input int exp_ph);
    logic [6:0] got, exp;
    got = {phase, line_seize, rcal_busy, acal_busy, link_ready};
    exp = {3'(exp_ph), exp_ph >= 2, exp_ph == 3, exp_ph == 4, exp_ph == 5};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got phase/seize/rc/ac/rdy=%b expected %b", req, got, exp);
    end
  endtask

  task automatic run_seq(input logic [1:0] s, input bit r, input bit a,
                         input int stop_k, input bit scramble);
    @(negedge clk);
    settle_sel = s; rcal_off = r; acal_off = a; offhook_req = 1'b1;
    for (int k = 0; k <= stop_k; k++) begin
      int e;
      @(negedge clk);
      e = ref_phase(k, s, r, a);
      if (scramble) check_out("R9 frozen config", e);
      else case (e)
        1: check_out("R2 latency", e);
        2: check_out("R3 settle", e);
        3: check_out("R4 rcal", e);
        4: check_out("R5 acal", e);
        default: check_out("R8 ready hold", e);
      endcase
      if (scramble) begin
        settle_sel = 2'($urandom); rcal_off = 1'($urandom); acal_off = 1'($urandom);
      end
    end
    offhook_req = 1'b0;
    @(negedge clk);
    check_out("R7 abort to idle", 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    check_out("R1 reset state", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 idle after reset", 0);
    // R3 every settling code, R6 full order, R11 exact lengths
    for (int s = 0; s < 4; s++) run_seq(2'(s), 0, 0, total_len(2'(s), 0, 0) + 4, 0);
    // R4 R5 skip combinations
    run_seq(2'b11, 1, 0, total_len(2'b11, 1, 0) + 3, 0);
    run_seq(2'b11, 0, 1, total_len(2'b11, 0, 1) + 3, 0);
    run_seq(2'b11, 1, 1, total_len(2'b11, 1, 1) + 3, 0);
    // R10 idle stays idle without a request
    repeat (5) begin @(negedge clk); check_out("R10 idle code", 0); end
    // R7 aborts at random points
    for (int i = 0; i < 5; i++) begin
      logic [1:0] s; bit r, a;
      s = 2'($urandom); r = 1'($urandom); a = 1'($urandom);
      run_seq(s, r, a, int'($urandom % total_len(s, r, a)), 0);
    end
    // R9 random runs with inputs scrambled mid-sequence
    for (int i = 0; i < 6; i++) begin
      logic [1:0] s; bit r, a;
      s = 2'($urandom); if (s == 2'b10) s = 2'b01;
      r = 1'($urandom); a = 1'($urandom);
      run_seq(s, r, a, total_len(s, r, a) + 2, 1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule